// File: doc/BRIEF.md
# Multi-channel burst drain controller

This block sits between a set of detector channels and the write side of a USB slave-FIFO bus. Each channel pushes its projection samples into a private buffer. The controller watches the fill level of every buffer. Once all of them hold at least one burst's worth of words, it starts a round. A round empties one burst from channel 0, then one from channel 1, and so on up to the last channel, and places the words on the shared bus.

The same bus also carries host commands, which a separate command path reads. That path raises a request and is granted the bus only at a burst boundary. A boundary is either the idle state between rounds or the point between two channels inside a round. Once granted, the command path holds the bus until it signals completion. An interrupted round then resumes with the next channel.

The endpoint's full flag stalls the data path in the same cycle it is raised. A channel whose buffer is already full discards further samples and raises a per-channel overflow flag. The flag stays set until reset.

Top module: `burst_drain_ctrl`

## Requirements
- R1: After reset, `wr_en`, `cmd_grant` and every bit of `ovf` are 0.
- R2: A round starts only when every channel buffer holds at least BURST words. The first write appears in the cycle after the edge on which the last buffer reaches BURST.
- R3: A round writes exactly BURST words from each channel. Channels go in ascending index order, and the words of each channel keep their arrival order.
- R4: `wr_en` is 0 in every cycle in which `bus_full` is 1. A stall neither loses nor repeats a word.
- R5: A `cmd_req` seen while the controller is idle makes `cmd_grant` 1 from the next cycle. The grant holds until the edge that samples `cmd_done`, after which it is 0.
- R6: A `cmd_req` raised during a channel's burst is not granted until that burst's last word has been written. It is then granted before the next channel starts. After `cmd_done`, the round resumes with that next channel.
- R7: A sample that arrives at a full buffer, with no read in the same cycle, is discarded. The channel's bit of `ovf` (bit i for channel i) is set and stays 1 until reset, and other channels' bits are unaffected.
- R8: When the controller is idle and both a command request and a ready round are pending, the command is granted first.
- R9: `wr_en` and `cmd_grant` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_valid | input | NCH | Per-channel sample strobe |
| ch_data | input | NCH*DW | Per-channel samples, channel i in bits [i*DW +: DW] |
| bus_full | input | 1 | Endpoint buffer full flag |
| cmd_req | input | 1 | Command path requests the bus |
| cmd_done | input | 1 | Command path releases the bus |
| wr_en | output | 1 | Write strobe to the slave-FIFO bus |
| wr_data | output | DW | Word on the slave-FIFO bus |
| cmd_grant | output | 1 | Bus granted to the command path |
| ovf | output | NCH | Sticky per-channel overflow flags |

## Verification
A sample written on edge N is counted at once. If it completes the last buffer's burst, `wr_en` stays low for the rest of that cycle and is high from edge N+1. `bus_full` gates `wr_en` in the same cycle without a register. `cmd_grant` rises one edge after an idle `cmd_req` and falls one edge after `cmd_done`. The bench drives inputs on the falling edge and samples the outputs one time unit later, so each sample sees the value that the next rising edge will commit. The run uses three channels, a four-word burst and a six-deep buffer. A bench model predicts every word, including dropped samples, and checks each write against it together with the exact latency at round start, grant and release.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CMD   = 2'd1,
        ST_BURST = 2'd2
    } seq_state_e;
endpackage

// File: rtl/bdc_chan_fifo.sv
module bdc_chan_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 512,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          ovf
);
    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
        logic          ovf;
    } fifo_s;

    fifo_s q, d;
    logic [DW-1:0] mem [DEPTH];
    logic accept;

    always_comb begin
        d      = q;
        accept = in_valid && ((q.count != CW'(DEPTH)) || pop);
        if (accept)
            d.wr_ptr = (q.wr_ptr == AW'(DEPTH - 1)) ? '0 : q.wr_ptr + 1'b1;
        if (pop)
            d.rd_ptr = (q.rd_ptr == AW'(DEPTH - 1)) ? '0 : q.rd_ptr + 1'b1;
        case ({accept, pop})
            2'b10:   d.count = q.count + 1'b1;
            2'b01:   d.count = q.count - 1'b1;
            default: d.count = q.count;
        endcase
        if (in_valid && !accept)
            d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (accept) mem[q.wr_ptr] <= in_data;
    end

    assign head  = mem[q.rd_ptr];
    assign count = q.count;
    assign ovf   = q.ovf;

    // R3: the sequencer never reads an empty buffer
    a_r3_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (q.count != '0));
    // R7: occupancy never exceeds the buffer depth
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.count <= CW'(DEPTH));
    // R7: a sample at a full buffer is discarded and flagged
    a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (q.count == CW'(DEPTH)) && !pop) |=> (q.ovf && (q.count == CW'(DEPTH))));
    // R7: the overflow flag is sticky
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(q.ovf) |-> q.ovf);
endmodule

// File: rtl/bdc_drain_seq.sv
module bdc_drain_seq
    import bdc_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int BURST = 512,
    localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int WCW  = (BURST > 1) ? $clog2(BURST) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ready,
    input  logic           bus_full,
    input  logic           cmd_req,
    input  logic           cmd_done,
    output logic           wr_en,
    output logic [CHW-1:0] ch_sel,
    output logic [NCH-1:0] pop,
    output logic           cmd_grant
);
    typedef struct packed {
        seq_state_e     state;
        logic [CHW-1:0] ch;
        logic [WCW-1:0] wcnt;
        logic           resume;
    } seq_s;

    seq_s q, d;
    logic last_word;

    always_comb begin
        d         = q;
        wr_en     = 1'b0;
        last_word = (q.wcnt == WCW'(BURST - 1));
        case (q.state)
            ST_IDLE: begin
                if (cmd_req) begin
                    d.state  = ST_CMD;
                    d.resume = 1'b0;
                end else if (&ready) begin
                    d.state = ST_BURST;
                    d.ch    = '0;
                    d.wcnt  = '0;
                end
            end
            ST_CMD: begin
                if (cmd_done) begin
                    d.state  = q.resume ? ST_BURST : ST_IDLE;
                    d.resume = 1'b0;
                end
            end
            ST_BURST: begin
                if (!bus_full) begin
                    wr_en = 1'b1;
                    if (last_word) begin
                        d.wcnt = '0;
                        if (q.ch == CHW'(NCH - 1)) begin
                            d.state = ST_IDLE;
                            d.ch    = '0;
                        end else begin
                            d.ch = q.ch + 1'b1;
                            if (cmd_req) begin
                                d.state  = ST_CMD;
                                d.resume = 1'b1;
                            end
                        end
                    end else begin
                        d.wcnt = q.wcnt + 1'b1;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
        for (int i = 0; i < NCH; i++)
            pop[i] = wr_en && (q.ch == CHW'(i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{state: ST_IDLE, ch: '0, wcnt: '0, resume: 1'b0};
        else        q <= d;
    end

    assign ch_sel    = q.ch;
    assign cmd_grant = (q.state == ST_CMD);

    // R2: a round is entered from idle only with every buffer ready
    a_r2_start_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_BURST) && ($past(q.state) == ST_IDLE)) |-> $past(&ready));
    // R3: the channel changes only after its last word was written
    a_r3_channel_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_BURST) && ($past(q.state) == ST_BURST) && (q.ch != $past(q.ch)))
        |-> $past(wr_en && last_word));
    // R6: a burst that is not on its final write stays on the bus
    a_r6_no_split: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_BURST) && !(wr_en && last_word)) |=> (q.state == ST_BURST));
    // R5: a grant begins only in response to a request
    a_r5_grant_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_grant) |-> $past(cmd_req));
endmodule

// File: rtl/burst_drain_ctrl.sv
module burst_drain_ctrl #(
    parameter int NCH   = 4,
    parameter int DW    = 16,
    parameter int BURST = 512,
    parameter int DEPTH = 512,
    localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    ch_valid,
    input  logic [NCH*DW-1:0] ch_data,
    input  logic              bus_full,
    input  logic              cmd_req,
    input  logic              cmd_done,
    output logic              wr_en,
    output logic [DW-1:0]     wr_data,
    output logic              cmd_grant,
    output logic [NCH-1:0]    ovf
);
    logic [NCH-1:0] ready;
    logic [NCH-1:0] pop;
    logic [CHW-1:0] ch_sel;
    logic [DW-1:0]  heads [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        logic [CW-1:0] cnt;
        bdc_chan_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (ch_valid[i]),
            .in_data  (ch_data[i*DW +: DW]),
            .pop      (pop[i]),
            .head     (heads[i]),
            .count    (cnt),
            .ovf      (ovf[i])
        );
        assign ready[i] = (cnt >= CW'(BURST));
    end

    bdc_drain_seq #(.NCH(NCH), .BURST(BURST)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready     (ready),
        .bus_full  (bus_full),
        .cmd_req   (cmd_req),
        .cmd_done  (cmd_done),
        .wr_en     (wr_en),
        .ch_sel    (ch_sel),
        .pop       (pop),
        .cmd_grant (cmd_grant)
    );

    assign wr_data = heads[ch_sel];

    // R4: no write strobe while the endpoint is full
    a_r4_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        bus_full |-> !wr_en);
    // R9: the bus has a single owner per cycle
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && cmd_grant));
endmodule

// File: tb/burst_drain_ctrl_bench.sv
`timescale 1ns/1ps
module burst_drain_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 3;
    localparam int DW    = 8;
    localparam int BURST = 4;
    localparam int DEPTH = 6;
    localparam int ROUND = NCH * BURST;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    ch_valid = '0;
    logic [NCH*DW-1:0] ch_data = '0;
    logic              bus_full = 1'b0;
    logic              cmd_req = 1'b0;
    logic              cmd_done = 1'b0;
    logic              wr_en;
    logic [DW-1:0]     wr_data;
    logic              cmd_grant;
    logic [NCH-1:0]    ovf;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] mdl [NCH][256];
    int mdl_wr [NCH];
    int mdl_rd [NCH];
    int seq_n  [NCH];
    int exp_ch = 0;
    int exp_k  = 0;
    int words_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_drain_ctrl #(.NCH(NCH), .DW(DW), .BURST(BURST), .DEPTH(DEPTH)) u_burst_drain_ctrl (
        .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_data(ch_data),
        .bus_full(bus_full), .cmd_req(cmd_req), .cmd_done(cmd_done),
        .wr_en(wr_en), .wr_data(wr_data), .cmd_grant(cmd_grant), .ovf(ovf)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic sync();
        @(negedge clk);
    endtask

    // one cycle of samples on the channels in mask, driven on the falling edge
    task automatic push(input logic [NCH-1:0] mask);
        sync();
        for (int c = 0; c < NCH; c++) begin
            ch_valid[c] = mask[c];
            ch_data[c*DW +: DW] = DW'((c << 6) | (seq_n[c] & 63));
            if (mask[c]) begin
                if (mdl_wr[c] - mdl_rd[c] < DEPTH) begin
                    mdl[c][mdl_wr[c] % 256] = DW'((c << 6) | (seq_n[c] & 63));
                    mdl_wr[c]++;
                end
                seq_n[c]++;
            end
        end
        sync();
        ch_valid = '0;
    endtask

    task automatic fill_all();
        for (int k = 0; k < BURST; k++) push('1);
    endtask

    task automatic wait_words(input int target, input string req);
        int guard = 0;
        while (words_seen < target && guard < 400) begin
            sync();
            #2;
            guard++;
        end
        check(words_seen == target, req, words_seen, target);
    endtask

    // monitor: one time unit after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && wr_en) begin
                logic [DW-1:0] exp_w;
                check(bus_full == 1'b0, "R4", int'(bus_full), 0);
                check(cmd_grant == 1'b0, "R9", int'(cmd_grant), 0);
                if (mdl_rd[exp_ch] < mdl_wr[exp_ch]) begin
                    exp_w = mdl[exp_ch][mdl_rd[exp_ch] % 256];
                    mdl_rd[exp_ch]++;
                    check(wr_data == exp_w, "R3", int'(wr_data), int'(exp_w));
                end else begin
                    check(1'b0, "R3 write from empty channel", int'(wr_data), -1);
                end
                words_seen++;
                exp_k++;
                if (exp_k == BURST) begin
                    exp_k = 0;
                    exp_ch = (exp_ch + 1) % NCH;
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base;
        int guard;
        logic [15:0] lfsr;
        for (int c = 0; c < NCH; c++) begin
            mdl_wr[c] = 0; mdl_rd[c] = 0; seq_n[c] = 0;
        end
        repeat (3) sync();
        rst_n = 1'b1;
        #2;
        // R1: reset state
        check(wr_en == 1'b0, "R1 wr_en", int'(wr_en), 0);
        check(cmd_grant == 1'b0, "R1 cmd_grant", int'(cmd_grant), 0);
        check(ovf == '0, "R1 ovf", int'(ovf), 0);

        // R2: one buffer short of a burst blocks the round
        for (int k = 0; k < BURST; k++) push(3'b011);
        for (int k = 0; k < BURST - 1; k++) push(3'b100);
        repeat (8) sync();
        #2;
        check(words_seen == 0, "R2 no early round", words_seen, 0);
        push(3'b100);
        #2;
        check(wr_en == 1'b0, "R2 one idle cycle", int'(wr_en), 0);
        sync();
        #2;
        check(wr_en == 1'b1, "R2 round starts", int'(wr_en), 1);
        wait_words(ROUND, "R3 round length");
        repeat (3) sync();
        #2;
        check(words_seen == ROUND, "R3 nothing extra", words_seen, ROUND);

        // R4: full flag stalls a round
        base = words_seen;
        sync();
        bus_full = 1'b1;
        fill_all();
        repeat (5) sync();
        #2;
        check(words_seen == base, "R4 stall holds", words_seen, base);
        lfsr = 16'hACE1;
        guard = 0;
        while (words_seen < base + ROUND && guard < 400) begin
            sync();
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            bus_full = lfsr[0];
            guard++;
        end
        bus_full = 1'b0;
        repeat (3) sync();
        #2;
        check(words_seen == base + ROUND, "R4 no loss or repeat", words_seen, base + ROUND);

        // R5: grant latency and release
        sync();
        cmd_req = 1'b1;
        #2;
        check(cmd_grant == 1'b0, "R5 not yet", int'(cmd_grant), 0);
        sync();
        #2;
        check(cmd_grant == 1'b1, "R5 granted", int'(cmd_grant), 1);
        cmd_req = 1'b0;
        repeat (3) sync();
        #2;
        check(cmd_grant == 1'b1, "R5 grant held", int'(cmd_grant), 1);
        cmd_done = 1'b1;
        sync();
        cmd_done = 1'b0;
        #2;
        check(cmd_grant == 1'b0, "R5 released", int'(cmd_grant), 0);

        // R8: command beats a ready round
        base = words_seen;
        sync();
        cmd_req = 1'b1;
        sync();
        fill_all();
        repeat (2) sync();
        cmd_done = 1'b1;
        sync();
        cmd_done = 1'b0;
        #2;
        check(cmd_grant == 1'b0, "R8 idle cycle", int'(cmd_grant), 0);
        sync();
        #2;
        check(cmd_grant == 1'b1, "R8 command first", int'(cmd_grant), 1);
        check(words_seen == base, "R8 no data", words_seen, base);
        cmd_req = 1'b0;
        cmd_done = 1'b1;
        sync();
        cmd_done = 1'b0;
        wait_words(base + ROUND, "R8 round after command");

        // R6: request inside a burst waits for the burst boundary
        repeat (2) sync();
        base = words_seen;
        fill_all();
        guard = 0;
        while (words_seen < base + 2 && guard < 50) begin sync(); #2; guard++; end
        cmd_req = 1'b1;
        guard = 0;
        while (!cmd_grant && guard < 50) begin sync(); #2; guard++; end
        check(cmd_grant == 1'b1, "R6 granted", int'(cmd_grant), 1);
        check(words_seen == base + BURST, "R6 burst not split", words_seen, base + BURST);
        repeat (3) sync();
        #2;
        check(words_seen == base + BURST, "R6 data held off", words_seen, base + BURST);
        cmd_req = 1'b0;
        cmd_done = 1'b1;
        sync();
        cmd_done = 1'b0;
        wait_words(base + ROUND, "R6 round resumes");

        // R7: overflow on one channel only
        repeat (2) sync();
        base = words_seen;
        for (int k = 0; k < DEPTH + 1; k++) push(3'b010);
        #2;
        check(ovf == 3'b010, "R7 flag on channel 1", int'(ovf), 2);
        for (int k = 0; k < BURST; k++) push(3'b101);
        wait_words(base + ROUND, "R7 first round");
        repeat (2) sync();
        #2;
        check(ovf == 3'b010, "R7 flag sticky", int'(ovf), 2);
        base = words_seen;
        for (int k = 0; k < BURST - (DEPTH - BURST); k++) push(3'b010);
        for (int k = 0; k < BURST; k++) push(3'b101);
        wait_words(base + ROUND, "R7 second round skips dropped sample");
        repeat (3) sync();
        for (int c = 0; c < NCH; c++)
            check(mdl_rd[c] == mdl_wr[c], "R3 buffers drained", mdl_rd[c], mdl_wr[c]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule